// File: doc/BRIEF.md
# Curvature Region and Boundary Finder

This block learns where the modes of a 64-bin feature histogram lie and where they separate. On a start request it walks the histogram once, issuing one read per bin in ascending order to a memory with one cycle of read latency. Each bin is tested for concave curvature against its two neighbours. The results form a 64-bit membership mask.

While the scan runs, a small state machine follows the pattern of curved and flat bins. In every flat stretch that lies between two curved stretches it keeps the lowest bin and records that position as a mode boundary. Up to seven boundaries are kept.

After the scan a sticky completion flag is raised, and a host read clears it. From then on the block answers lookups combinationally. For two 6-bit feature values, the peak and the hyperpolarisation feature of a spike, it returns the region index of each. It also returns one bit telling whether both features fall on curved bins, which makes the spike usable for training a cluster table.

Top module: `curv_boundary_finder`

## Requirements
- R1: After reset no read is requested, the completion flag is low, every region index is 0 and the membership bit is 0.
- R2: Once a start pulse is accepted, the block requests exactly 64 reads on consecutive cycles, addresses 0 up to 63 in order. It takes the data one cycle after each request.
- R3: Bin i is curved when 2*F(i) > F(i-1) + F(i+1) + 8, with F(-1) = F(64) = 0. Equality does not count. Bin i's flag is mask bit i.
- R4: The membership output is 1 only when the mask bits addressed by both feature inputs are 1.
- R5: Every run of flat bins with a curved bin on both sides yields one boundary: the position of its smallest bin, the lowest position on ties. Flat runs before the first curved bin or after the last one yield none.
- R6: Only the first seven boundaries of a scan, in ascending position, are kept; later ones are dropped.
- R7: A feature's region index is the number of kept boundaries whose position is less than or equal to the feature value.
- R8: The completion flag rises on the 67th rising edge after the edge that accepted start. It then holds until a cycle with the host-read input high, and is low after that edge.
- R9: A new scan discards all boundaries of the previous scan and rebuilds the mask from the new data.
- R10: A start pulse while the completion flag is set is ignored: no read is issued and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Begins a scan when the block is idle |
| host_rd | input | 1 | Host read strobe; clears the completion flag |
| mem_rd_en | output | 1 | Histogram read request |
| mem_rd_addr | output | 6 | Histogram bin address |
| mem_rd_data | input | 16 | Bin count, valid one cycle after a request |
| scan_done | output | 1 | Sticky completion flag |
| feat_pk | input | 6 | Peak feature value for lookup |
| feat_hp | input | 6 | Hyperpolarisation feature value for lookup |
| region_pk | output | 3 | Region index of the peak feature |
| region_hp | output | 3 | Region index of the hyperpolarisation feature |
| spike_informative | output | 1 | Both features fall on curved bins |

## Verification
The mask and the boundary registers are seen only through the lookup ports. An error inside shows as a wrong region index or membership bit for some feature value as soon as the scan finishes. These are an off-by-one in the buffer latency correction, a missed or extra boundary push, or a wrong tie rule for the minimum. Sweeping every feature value after each scan therefore exposes every bit of hidden state within 64 cycles of completion. Errors in the scan sequencer show earlier, in the read address stream and in the exact cycle the completion flag rises.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_RUN,
    SC_DONE
  } scan_st_t;

  typedef enum logic [2:0] {
    TK_STBY,
    TK_FIRST,
    TK_PEAK,
    TK_TROUGH,
    TK_CROSS,
    TK_PEAK2
  } trk_st_t;

  // Concave-curvature test on a three-bin window, widened so no sum wraps.
  function automatic logic curv_hit(input logic [31:0] lft, input logic [31:0] mid,
                                    input logic [31:0] rgt, input logic [31:0] off);
    logic [33:0] twice;
    logic [33:0] side;
    twice = {1'b0, mid, 1'b0};
    side  = 34'(lft) + 34'(rgt) + 34'(off);
    return twice > side;
  endfunction

endpackage

// File: rtl/cbf_window.sv
module cbf_window #(
  parameter int DW  = 16,
  parameter int OFF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] center,
  output logic          curved
);
  import cbf_pkg::*;

  logic [DW-1:0] w_old, w_mid, w_new;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      w_old <= '0;
      w_mid <= '0;
      w_new <= '0;
    end else if (shift) begin
      w_new <= din;
      w_mid <= w_new;
      w_old <= w_mid;
    end
  end

  assign center = w_mid;
  assign curved = curv_hit(32'(w_old), 32'(w_mid), 32'(w_new), 32'(OFF));

endmodule

// File: rtl/cbf_tracker.sv
module cbf_tracker #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int NB = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           fin,
  input  logic           eval,
  input  logic           curved,
  input  logic [DW-1:0]  center,
  input  logic [AW-1:0]  bin,
  output logic [NB*AW-1:0] bnd_flat,
  output logic [NB-1:0]  bvld,
  output logic           push_ev
);
  import cbf_pkg::*;

  trk_st_t       st, nst;
  logic [DW-1:0] run_min;
  logic [AW-1:0] min_pos;
  logic [AW-1:0] bnd_q [NB];
  logic          gap_bin;
  logic          take;

  always_comb begin
    nst     = st;
    push_ev = 1'b0;
    if (clr) begin
      nst = TK_FIRST;
    end else if (eval) begin
      case (st)
        TK_FIRST:  if (curved) nst = TK_PEAK;
        TK_PEAK:   if (!curved) nst = TK_TROUGH;
        TK_TROUGH: if (curved) begin
                     nst     = TK_CROSS;
                     push_ev = 1'b1;
                   end
        TK_CROSS:  nst = curved ? TK_PEAK2 : TK_TROUGH;
        TK_PEAK2:  if (!curved) nst = TK_TROUGH;
        default:   nst = st;
      endcase
    end
    if (fin) nst = TK_STBY;
  end

  assign gap_bin = eval && !curved &&
                   (st == TK_PEAK || st == TK_TROUGH || st == TK_CROSS || st == TK_PEAK2);
  assign take    = gap_bin && (st != TK_TROUGH || center < run_min);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= TK_STBY;
      run_min <= '1;
      min_pos <= '0;
    end else begin
      st <= nst;
      if (take) begin
        run_min <= center;
        min_pos <= bin;
      end else if (nst != TK_TROUGH) begin
        run_min <= '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bvld <= '0;
      for (int i = 0; i < NB; i++) bnd_q[i] <= '0;
    end else if (push_ev && !bvld[0]) begin
      for (int i = 0; i < NB - 1; i++) bnd_q[i] <= bnd_q[i+1];
      bnd_q[NB-1] <= min_pos;
      bvld        <= {1'b1, bvld[NB-1:1]};
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_flat
    assign bnd_flat[g*AW +: AW] = bnd_q[g];
  end

endmodule

// File: rtl/cbf_lookup.sv
module cbf_lookup #(
  parameter int AW = 6,
  parameter int NB = 7,
  parameter int IW = 3
) (
  input  logic [AW-1:0]    feat,
  input  logic [NB*AW-1:0] bnd_flat,
  input  logic [NB-1:0]    bvld,
  output logic [IW-1:0]    region
);
  logic [NB-1:0] at_or_above;

  for (genvar g = 0; g < NB; g++) begin : g_cmp
    assign at_or_above[g] = bvld[g] && (feat >= bnd_flat[g*AW +: AW]);
  end

  assign region = IW'($countones(at_or_above));

endmodule

// File: rtl/curv_boundary_finder.sv
module curv_boundary_finder #(
  parameter int NBINS = 64,
  parameter int DW    = 16,
  parameter int NB    = 7,
  parameter int OFF   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scan_start,
  input  logic                     host_rd,
  output logic                     mem_rd_en,
  output logic [$clog2(NBINS)-1:0] mem_rd_addr,
  input  logic [DW-1:0]            mem_rd_data,
  output logic                     scan_done,
  input  logic [$clog2(NBINS)-1:0] feat_pk,
  input  logic [$clog2(NBINS)-1:0] feat_hp,
  output logic [$clog2(NB+1)-1:0]  region_pk,
  output logic [$clog2(NB+1)-1:0]  region_hp,
  output logic                     spike_informative
);
  import cbf_pkg::*;

  localparam int AW = $clog2(NBINS);
  localparam int IW = $clog2(NB + 1);
  localparam int CW = $clog2(NBINS + 3);
  localparam logic [CW-1:0] C_BINS = CW'(NBINS);
  localparam logic [CW-1:0] C_PAD  = CW'(NBINS + 1);
  localparam logic [CW-1:0] C_LAT  = CW'(3);
  localparam logic [CW-1:0] C_LAST = CW'(NBINS + 2);

  scan_st_t        sst;
  logic [CW-1:0]   cnt;
  logic [NBINS-1:0] mask;

  // Named internal events for the checker.
  logic            clr_ev, fin_ev, shift_ev, eval_ev, push_ev, curved;
  logic [DW-1:0]   center, win_din;
  logic [AW-1:0]   bin;
  logic [NB*AW-1:0] bnd_flat;
  logic [NB-1:0]   bvld;

  assign clr_ev   = (sst == SC_IDLE) && scan_start;
  assign fin_ev   = (sst == SC_RUN) && (cnt == C_LAST);
  assign shift_ev = (sst == SC_RUN) && (cnt != '0) && (cnt <= C_PAD);
  assign eval_ev  = (sst == SC_RUN) && (cnt >= C_LAT);
  assign win_din  = (cnt <= C_BINS) ? mem_rd_data : '0;
  assign bin      = AW'(cnt - C_LAT);

  assign mem_rd_en   = (sst == SC_RUN) && (cnt < C_BINS);
  assign mem_rd_addr = AW'(cnt);
  assign scan_done   = (sst == SC_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sst <= SC_IDLE;
      cnt <= '0;
    end else begin
      case (sst)
        SC_IDLE: if (scan_start) begin
                   sst <= SC_RUN;
                   cnt <= '0;
                 end
        SC_RUN:  begin
                   cnt <= cnt + 1'b1;
                   if (cnt == C_LAST) sst <= SC_DONE;
                 end
        SC_DONE: if (host_rd) sst <= SC_IDLE;
        default: sst <= SC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask <= '0;
    else if (eval_ev) mask <= {curved, mask[NBINS-1:1]};
  end

  cbf_window #(.DW(DW), .OFF(OFF)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(clr_ev), .shift(shift_ev),
    .din(win_din), .center(center), .curved(curved)
  );

  cbf_tracker #(.AW(AW), .DW(DW), .NB(NB)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr(clr_ev), .fin(fin_ev), .eval(eval_ev),
    .curved(curved), .center(center), .bin(bin),
    .bnd_flat(bnd_flat), .bvld(bvld), .push_ev(push_ev)
  );

  cbf_lookup #(.AW(AW), .NB(NB), .IW(IW)) u_lk_pk (
    .feat(feat_pk), .bnd_flat(bnd_flat), .bvld(bvld), .region(region_pk)
  );

  cbf_lookup #(.AW(AW), .NB(NB), .IW(IW)) u_lk_hp (
    .feat(feat_hp), .bnd_flat(bnd_flat), .bvld(bvld), .region(region_hp)
  );

  assign spike_informative = mask[feat_pk] & mask[feat_hp];

endmodule

// File: rtl/cbf_chk.sv
module cbf_chk #(
  parameter int AW = 6,
  parameter int NB = 7,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rd,
  input logic          mem_rd_en,
  input logic [AW-1:0] mem_rd_addr,
  input logic          scan_done,
  input logic          eval_ev,
  input logic          push_ev,
  input logic [NB-1:0] bvld,
  input logic [IW-1:0] region_pk,
  input logic [IW-1:0] region_hp
);
  localparam logic [NB-1:0] TOP_BIT = NB'(1) << (NB - 1);

  // R2
  rd_addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_rd_addr != '0) |-> ($past(mem_rd_en) && mem_rd_addr == $past(mem_rd_addr) + 1'b1));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && !host_rd) |=> scan_done);

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && host_rd) |=> !scan_done);

  // R10
  no_read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !mem_rd_en);

  // R5
  push_in_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |-> eval_ev);

  // R6
  bvld_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvld & ~(bvld >> 1) & ~TOP_BIT) == '0);

  // R6
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && !bvld[0]) |=> ($countones(bvld) == $countones($past(bvld)) + 1));

  // R6
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ev && bvld[0]) |=> $stable(bvld));

  // R7
  region_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(region_pk) <= $countones(bvld)) && (int'(region_hp) <= $countones(bvld)));

endmodule

bind curv_boundary_finder cbf_chk #(.AW(AW), .NB(NB), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .scan_done(scan_done), .eval_ev(eval_ev),
  .push_ev(push_ev), .bvld(bvld), .region_pk(region_pk), .region_hp(region_hp)
);

// File: tb/tb_curv_boundary_finder.sv
module tb_curv_boundary_finder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_start = 1'b0;
  logic        host_rd = 1'b0;
  logic        mem_rd_en;
  logic [5:0]  mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        scan_done;
  logic [5:0]  feat_pk = '0;
  logic [5:0]  feat_hp = '0;
  logic [2:0]  region_pk, region_hp;
  logic        spike_informative;

  always #10 clk = ~clk;

  curv_boundary_finder dut (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .host_rd(host_rd),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .scan_done(scan_done), .feat_pk(feat_pk), .feat_hp(feat_hp),
    .region_pk(region_pk), .region_hp(region_hp), .spike_informative(spike_informative)
  );

  int checks = 0;
  int errors = 0;
  int hist [64];
  bit exp_inf [64];
  int exp_bnd [7];
  int exp_nb = 0;
  int rd_cnt = 0;
  int exp_addr = 0;

  typedef struct {
    int    pk, hp, rpk, rhp, inf;
    string rtag, itag;
  } item_t;
  item_t sb_q [$];

  // Histogram memory model with one cycle read latency.
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= 16'(hist[mem_rd_addr]);

  task automatic check(input bit ok, input string tag, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  // Read stream monitor (R2).
  always @(negedge clk) if (mem_rd_en) begin
    check(int'(mem_rd_addr) == exp_addr, "R2", "read address", int'(mem_rd_addr), exp_addr);
    exp_addr++;
    rd_cnt++;
  end

  // Scoreboard monitor.
  always @(negedge clk) if (sb_q.size() > 0) begin
    item_t it;
    it = sb_q.pop_front();
    check(int'(region_pk) == it.rpk, it.rtag, $sformatf("region_pk f=%0d", it.pk), int'(region_pk), it.rpk);
    check(int'(region_hp) == it.rhp, it.rtag, $sformatf("region_hp f=%0d", it.hp), int'(region_hp), it.rhp);
    check(int'(spike_informative) == it.inf, it.itag,
          $sformatf("informative pk=%0d hp=%0d", it.pk, it.hp), int'(spike_informative), it.inf);
  end

  function automatic int region_of(input int f);
    int n = 0;
    for (int i = 0; i < exp_nb; i++) if (f >= exp_bnd[i]) n++;
    return n;
  endfunction

  // Expected mask and boundaries, from R3, R5, R6.
  task automatic model();
    bit seen = 0, gap = 0;
    int gmin = 0, gpos = 0;
    exp_nb = 0;
    for (int i = 0; i < 64; i++) begin
      int l, r;
      l = (i > 0) ? hist[i-1] : 0;
      r = (i < 63) ? hist[i+1] : 0;
      exp_inf[i] = (2 * hist[i]) > (l + r + 8);
    end
    for (int i = 0; i < 64; i++) begin
      if (exp_inf[i]) begin
        if (gap && exp_nb < 7) begin
          exp_bnd[exp_nb] = gpos;
          exp_nb++;
        end
        gap = 0;
        seen = 1;
      end else if (seen) begin
        if (!gap) begin
          gap = 1; gmin = hist[i]; gpos = i;
        end else if (hist[i] < gmin) begin
          gmin = hist[i]; gpos = i;
        end
      end
    end
  endtask

  task automatic probe(input int pk, input int hp, input int rpk, input int rhp, input int inf,
                       input string rtag, input string itag);
    item_t it;
    @(posedge clk); #2;
    feat_pk = 6'(pk);
    feat_hp = 6'(hp);
    it.pk = pk; it.hp = hp; it.rpk = rpk; it.rhp = rhp; it.inf = inf;
    it.rtag = rtag; it.itag = itag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(input string rtag);
    for (int f = 0; f < 64; f++)
      probe(f, f, region_of(f), region_of(f), int'(exp_inf[f]), rtag, "R3");
    for (int f = 0; f < 64; f++) begin
      int h = (f * 7 + 3) % 64;
      probe(f, h, region_of(f), region_of(h), int'(exp_inf[f] && exp_inf[h]), rtag, "R4");
    end
    drain();
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 64; i++) hist[i] = 0;
  endtask

  task automatic add_bump(input int c, input int h, input int s);
    for (int i = 0; i < 64; i++) begin
      int v = h - s * (i - c) * (i - c);
      if (v > 0) hist[i] += v;
    end
  endtask

  task automatic run_scan();
    int n = 0;
    model();
    rd_cnt = 0;
    exp_addr = 0;
    @(posedge clk); #2 scan_start = 1'b1;
    @(posedge clk); #2 scan_start = 1'b0;
    forever begin
      @(posedge clk); #1;
      n++;
      if (scan_done || n > 200) break;
    end
    // R8: done on the 67th edge after the accepting edge
    check(n == 67, "R8", "edges to done", n, 67);
    check(rd_cnt == 64, "R2", "read count", rd_cnt, 64);
    // host read to leave done
    @(posedge clk); #2 host_rd = 1'b1;
    @(posedge clk); #2 host_rd = 1'b0;
    check(scan_done == 1'b0, "R8", "done after host read", int'(scan_done), 0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog expired got 1 exp 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_hist();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(scan_done == 1'b0, "R1", "done after reset", int'(scan_done), 0);
    check(mem_rd_en == 1'b0, "R1", "read after reset", int'(mem_rd_en), 0);
    exp_nb = 0;
    probe(63, 0, 0, 0, 0, "R1", "R1");
    probe(12, 40, 0, 0, 0, "R1", "R1");
    drain();

    // Scan A: three separated modes, zero troughs with ties
    clear_hist();
    add_bump(10, 100, 5); add_bump(28, 100, 5); add_bump(46, 100, 5);
    run_scan();
    check(exp_nb == 2 && exp_bnd[0] == 15, "R5", "model boundary A0", exp_bnd[0], 15);
    sweep("R7/R5");

    // Scan A again to test sticky done and ignored start
    begin
      int n = 0;
      rd_cnt = 0; exp_addr = 0;
      @(posedge clk); #2 scan_start = 1'b1;
      @(posedge clk); #2 scan_start = 1'b0;
      while (!scan_done && n < 200) begin @(posedge clk); #1; n++; end
      repeat (5) @(posedge clk);
      #1 check(scan_done == 1'b1, "R8", "done held without read", int'(scan_done), 1);
      n = rd_cnt;
      @(posedge clk); #2 scan_start = 1'b1;
      @(posedge clk); #2 scan_start = 1'b0;
      repeat (4) @(posedge clk);
      #1 check(rd_cnt == n, "R10", "reads after start in done", rd_cnt, n);
      check(scan_done == 1'b1, "R10", "done after ignored start", int'(scan_done), 1);
      @(posedge clk); #2 host_rd = 1'b1;
      @(posedge clk); #2 host_rd = 1'b0;
      check(scan_done == 1'b0, "R8", "done cleared", int'(scan_done), 0);
    end

    // Scan B: ten narrow modes, nine gaps, only seven kept
    clear_hist();
    for (int c = 3; c <= 57; c += 6) add_bump(c, 60, 20);
    run_scan();
    check(exp_nb == 7, "R6", "model boundary count", exp_nb, 7);
    sweep("R7/R6");

    // Scan C: offset edge, leading flat run, non-zero trough with a tie
    clear_hist();
    hist[5] = 4; hist[12] = 5; hist[20] = 5; hist[30] = 5;
    add_bump(44, 100, 5); add_bump(53, 100, 5);
    run_scan();
    probe(5, 12, region_of(5), region_of(12), 0, "R7", "R3");
    probe(12, 20, region_of(12), region_of(20), 1, "R7", "R4");
    probe(48, 47, region_of(48), region_of(47), 0, "R5", "R4");
    drain();
    sweep("R7/R5");

    // Scan D: empty histogram clears all boundaries and the mask
    clear_hist();
    run_scan();
    for (int f = 0; f < 64; f += 9) probe(f, 63 - f, 0, 0, 0, "R9", "R9");
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule